// File: doc/BRIEF.md
# Receive Byte Buffer with Run Detector and Idle Timeout

This block takes received characters from a serial controller's receive request strobe and holds them in a deep byte queue until the host reads them through a small register port. The host reads characters in arrival order from a data register. A read-only status register reports the fill level. A second register holds interrupt flags that the host clears by writing ones to them.

Two detectors run on the stream of stored bytes. The run detector counts how many times in a row a programmable character has been stored. When that run reaches a programmable length, it raises a flag. The idle timer counts character times, each one a programmable number of system clocks. It raises a flag when the queue holds data and no new byte has been stored for a programmed number of character times. Both flags reach the interrupt output only when the host selects the combined source. Otherwise the output carries only the controller's own interrupt.

Top module: `rxb_top`

## Requirements
- R1: After reset, the control register reads 0, which means the buffer is disabled and both detectors are off. The status register reads 0x01 and the flag register reads 0x00.
- R2: Control bit 0 enables the buffer. While it is set, each `wr_req_i` pulse stores `wr_data_i`. Reads of the data register (address 0) with `reg_re_i` return the stored bytes in order. Status bit 0 is set when the buffer is empty, bit 1 when it is full, and bit 2 when it is at least half full.
- R3: The buffer holds DEPTH bytes. A byte that arrives while the buffer is full is dropped. Such a drop sets status bit 3 (overrun), which stays set until a software reset.
- R4: A read of the data register while the buffer is empty returns the byte delivered by the previous read and does not move the pointers.
- R5: While control bit 1 is set, the buffer is held empty and incoming bytes are dropped. Entering this state also clears the overrun bit.
- R6: While control bit 0 is clear, incoming bytes are ignored.
- R7: With control bit 2 set and a nonzero run length (address 5), flag bit 0 sets when the character at address 4 has been stored that many times in a row. After each match the run count starts again from zero.
- R8: A stored byte that differs from the run character resets the run count to zero. A run length of zero, or a clear control bit 2, stops all matching.
- R9: A character time is the value at address 7 plus 1 clocks. Suppose the idle limit at address 6 is nonzero and the buffer is not empty. Flag bit 1 then sets limit × (prescale+1) clocks after the last stored byte. It sets only once per idle period. A stored byte restarts the count, and a limit of zero disables the timer.
- R10: Flag bits (address 3) are cleared only by writing 1 to them. Writing 0 leaves them unchanged.
- R11: `irq_o` equals `scc_irq_i` OR (control bit 3 AND any flag bit set).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_req_i | input | 1 | Receive request strobe from the serial controller, one byte per cycle |
| wr_data_i | input | DW | Received character |
| reg_we_i | input | 1 | Host register write strobe |
| reg_re_i | input | 1 | Host register read strobe; pops the buffer at address 0 |
| reg_addr_i | input | 3 | Host register address |
| reg_wdata_i | input | DW | Host write data |
| reg_rdata_o | output | DW | Host read data, combinational from the address |
| scc_irq_i | input | 1 | Interrupt from the serial controller |
| irq_o | output | 1 | Combined interrupt output |

## Verification
The checker assumes that every input is steady across each rising clock edge. It also assumes that a host write and a host data read never target the same cycle's state in conflicting ways. It makes no assumption about how often bytes arrive. A receive request may come in any cycle, including one in which the host pops the buffer or writes the control register. The bench drives every input on the falling edge and issues at most one host access per cycle. Its receive pulses land only on whole-cycle boundaries, so the timeout counts it predicts from the requirement line up exactly with the design's clock edges.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
  localparam logic [2:0] A_DATA = 3'd0;
  localparam logic [2:0] A_CTRL = 3'd1;
  localparam logic [2:0] A_STAT = 3'd2;
  localparam logic [2:0] A_FLAG = 3'd3;
  localparam logic [2:0] A_PCHR = 3'd4;
  localparam logic [2:0] A_PLEN = 3'd5;
  localparam logic [2:0] A_TLIM = 3'd6;
  localparam logic [2:0] A_PRE  = 3'd7;

  localparam int C_EN   = 0;
  localparam int C_SRST = 1;
  localparam int C_PEN  = 2;
  localparam int C_SRC  = 3;
  localparam int C_W    = 4;

  localparam int F_PAT = 0;
  localparam int F_TMO = 1;
  localparam int F_W   = 2;
endpackage

// File: rtl/rxb_fifo.sv
module rxb_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [DW-1:0] din_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [AW:0]   count_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW:0]   wptr_q, rptr_q;
  logic          do_push, do_pop;

  assign empty_o = (wptr_q == rptr_q);
  assign full_o  = (wptr_q[AW] != rptr_q[AW]) && (wptr_q[AW-1:0] == rptr_q[AW-1:0]);
  assign count_o = wptr_q - rptr_q;
  assign do_push = push_i && !full_o && !clr_i;
  assign do_pop  = pop_i && !empty_o && !clr_i;
  assign head_o  = mem[rptr_q[AW-1:0]];

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wptr_q[AW-1:0]] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else if (clr_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      if (do_push) wptr_q <= wptr_q + 1'b1;
      if (do_pop)  rptr_q <= rptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/rxb_pattern.sv
module rxb_pattern #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          vld_i,
  input  logic [DW-1:0] byte_i,
  input  logic [DW-1:0] chr_i,
  input  logic [DW-1:0] len_i,
  output logic          hit_o
);
  logic [DW-1:0] run_q;
  logic [DW:0]   run_nxt;
  logic          armed, same;

  assign run_nxt = {1'b0, run_q} + 1'b1;
  assign armed   = vld_i && !clr_i && (len_i != '0);
  assign same    = (byte_i == chr_i);
  assign hit_o   = armed && same && (run_nxt == {1'b0, len_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             run_q <= '0;
    else if (clr_i)          run_q <= '0;
    else if (armed) begin
      if (!same || hit_o)    run_q <= '0;
      else                   run_q <= run_nxt[DW-1:0];
    end
  end
endmodule

// File: rtl/rxb_idle.sv
module rxb_idle #(
  parameter int PW = 8,
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          active_i,
  input  logic [PW-1:0] pre_i,
  input  logic [TW-1:0] lim_i,
  output logic          fire_o
);
  logic [PW-1:0] pre_q;
  logic [TW-1:0] chr_q;
  logic [TW:0]   chr_nxt;
  logic          tick, run;

  assign run     = active_i && !clr_i && (lim_i != '0);
  assign tick    = (pre_q == pre_i);
  assign chr_nxt = {1'b0, chr_q} + 1'b1;
  assign fire_o  = run && tick && (chr_nxt == {1'b0, lim_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      chr_q <= '0;
    end else if (!run) begin
      pre_q <= '0;
      chr_q <= '0;
    end else begin
      pre_q <= tick ? '0 : pre_q + 1'b1;
      // saturate at the limit so the flag fires once per idle period
      if (tick && (chr_q < lim_i)) chr_q <= chr_nxt[TW-1:0];
    end
  end
endmodule

// File: rtl/rxb_top.sv
module rxb_top
  import rxb_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_req_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          reg_we_i,
  input  logic          reg_re_i,
  input  logic [2:0]    reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic          scc_irq_i,
  output logic          irq_o
);
  logic [C_W-1:0] ctrl_q;
  logic [F_W-1:0] flag_q, flag_set, flag_clr;
  logic [DW-1:0]  pchr_q, plen_q, tlim_q, pre_q, last_q, head;
  logic           ovr_q, empty, full, push_req, accept, pop, srst, ctl_en, pen, src;
  logic [AW:0]    count;

  assign ctl_en   = ctrl_q[C_EN];
  assign srst     = ctrl_q[C_SRST];
  assign pen      = ctrl_q[C_PEN];
  assign src      = ctrl_q[C_SRC];
  assign push_req = wr_req_i && ctl_en && !srst;
  assign accept   = push_req && !full;
  assign pop      = reg_re_i && (reg_addr_i == A_DATA) && !empty;
  assign flag_clr = (reg_we_i && reg_addr_i == A_FLAG) ? reg_wdata_i[F_W-1:0] : '0;

  rxb_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni, .clr_i(srst), .push_i(accept), .din_i(wr_data_i),
    .pop_i(pop), .head_o(head), .empty_o(empty), .full_o(full), .count_o(count)
  );

  rxb_pattern #(.DW(DW)) u_pat (
    .clk_i, .rst_ni, .clr_i(srst || !pen), .vld_i(accept), .byte_i(wr_data_i),
    .chr_i(pchr_q), .len_i(plen_q), .hit_o(flag_set[F_PAT])
  );

  rxb_idle #(.PW(DW), .TW(DW)) u_idle (
    .clk_i, .rst_ni, .clr_i(srst || accept), .active_i(!empty),
    .pre_i(pre_q), .lim_i(tlim_q), .fire_o(flag_set[F_TMO])
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      pchr_q <= '0;
      plen_q <= '0;
      tlim_q <= '0;
      pre_q  <= '0;
    end else if (reg_we_i) begin
      case (reg_addr_i)
        A_CTRL:  ctrl_q <= reg_wdata_i[C_W-1:0];
        A_PCHR:  pchr_q <= reg_wdata_i;
        A_PLEN:  plen_q <= reg_wdata_i;
        A_TLIM:  tlim_q <= reg_wdata_i;
        A_PRE:   pre_q  <= reg_wdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= '0;
      ovr_q  <= 1'b0;
      last_q <= '0;
    end else begin
      flag_q <= (flag_q & ~flag_clr) | flag_set;  // set wins over clear
      if (srst)                 ovr_q <= 1'b0;
      else if (push_req && full) ovr_q <= 1'b1;
      if (pop) last_q <= head;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_DATA: reg_rdata_o = empty ? last_q : head;
      A_CTRL: reg_rdata_o[C_W-1:0] = ctrl_q;
      A_STAT: reg_rdata_o[3:0] = {ovr_q, count >= (AW+1)'(DEPTH/2), full, empty};
      A_FLAG: reg_rdata_o[F_W-1:0] = flag_q;
      A_PCHR: reg_rdata_o = pchr_q;
      A_PLEN: reg_rdata_o = plen_q;
      A_TLIM: reg_rdata_o = tlim_q;
      A_PRE:  reg_rdata_o = pre_q;
      default: ;
    endcase
  end

  assign irq_o = scc_irq_i || (src && (flag_q != '0));
endmodule

// File: rtl/rxb_chk.sv
module rxb_chk #(
  parameter int FW = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          srst_i,
  input logic          en_i,
  input logic          src_i,
  input logic          empty_i,
  input logic          full_i,
  input logic          ovr_i,
  input logic [FW-1:0] flag_i,
  input logic [FW-1:0] clr_i,
  input logic          scc_irq_i,
  input logic          irq_o
);
  // R3
  empty_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(empty_i && full_i));
  // R3
  ovr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ovr_i) && !$past(srst_i) |-> ovr_i);
  // R5
  srst_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> empty_i);
  // R6
  disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_i && !en_i |=> empty_i);
  // R10
  pat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(flag_i[0]) && !$past(clr_i[0]) |-> flag_i[0]);
  // R10
  tmo_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(flag_i[1]) && !$past(clr_i[1]) |-> flag_i[1]);
  // R11
  irq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !src_i && !scc_irq_i |-> !irq_o);
  // R11
  irq_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_i && (flag_i != '0) |-> irq_o);
endmodule

bind rxb_top rxb_chk #(.FW(2)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .srst_i(srst), .en_i(ctl_en), .src_i(src),
  .empty_i(empty), .full_i(full), .ovr_i(ovr_q), .flag_i(flag_q), .clr_i(flag_clr),
  .scc_irq_i(scc_irq_i), .irq_o(irq_o)
);

// File: tb/sim_rxb_top.sv
`timescale 1ns/1ps
module sim_rxb_top;
  localparam int DW    = 8;
  localparam int DEPTH = 1024;
  localparam int NV    = 8;
  localparam logic [DW-1:0] VEC [NV] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80, 8'h7F, 8'h3C};

  logic clk = 0, rst_ni = 0;
  logic wr_req = 0, we = 0, re = 0, scc_irq = 0;
  logic [DW-1:0] wr_data = '0, wdata = '0, rdata;
  logic [2:0] addr = '0;
  logic irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rxb_top #(.DW(DW), .DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_req_i(wr_req), .wr_data_i(wr_data),
    .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .scc_irq_i(scc_irq), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [DW-1:0] d);
    @(negedge clk); re = 1; addr = a;
    #1 d = rdata;
    @(negedge clk); re = 0;
  endtask

  task automatic push(input logic [DW-1:0] d);
    @(negedge clk); wr_req = 1; wr_data = d;
    @(negedge clk); wr_req = 0;
  endtask

  task automatic irq_is(input string req, input logic exp);
    #1 chk(req, {7'd0, irq}, {7'd0, exp});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R1 reset state
    rreg(3'd1, v); chk("R1 ctrl", v, 8'h00);
    rreg(3'd2, v); chk("R1 stat", v, 8'h01);
    rreg(3'd3, v); chk("R1 flags", v, 8'h00);
    irq_is("R1 irq idle", 1'b0);
    // R11 controller interrupt passes through
    scc_irq = 1; irq_is("R11 scc pass", 1'b1); scc_irq = 0;
    // R6 disabled buffer ignores bytes
    push(8'h33);
    rreg(3'd2, v); chk("R6 disabled", v, 8'h01);
    wreg(3'd1, 8'h09);
    // R2 table walk
    for (int i = 0; i < NV; i++) push(VEC[i]);
    rreg(3'd2, v); chk("R2 stat partial", v, 8'h00);
    for (int i = 0; i < NV; i++) begin
      rreg(3'd0, v); chk("R2 order", v, VEC[i]);
    end
    rreg(3'd2, v); chk("R2 stat drained", v, 8'h01);
    // R4 empty read
    rreg(3'd0, v); chk("R4 empty read", v, VEC[NV-1]);
    rreg(3'd2, v); chk("R4 still empty", v, 8'h01);
    push(8'h11);
    rreg(3'd0, v); chk("R4 pointers kept", v, 8'h11);
    // R7 / R8 run detector
    wreg(3'd4, 8'h7E); wreg(3'd5, 8'd3); wreg(3'd1, 8'h0D);
    push(8'h7E); push(8'h7E); push(8'h41); push(8'h7E); push(8'h7E);
    rreg(3'd3, v); chk("R8 broken run", v, 8'h00);
    push(8'h7E);
    rreg(3'd3, v); chk("R7 run matched", v, 8'h01);
    irq_is("R11 flag irq", 1'b1);
    wreg(3'd1, 8'h05);
    irq_is("R11 source off", 1'b0);
    wreg(3'd1, 8'h0D);
    wreg(3'd3, 8'h02);
    rreg(3'd3, v); chk("R10 write zero keeps", v, 8'h01);
    wreg(3'd3, 8'h01);
    rreg(3'd3, v); chk("R10 write one clears", v, 8'h00);
    push(8'h7E); push(8'h7E);
    rreg(3'd3, v); chk("R7 restart after match", v, 8'h00);
    push(8'h7E);
    rreg(3'd3, v); chk("R7 second match", v, 8'h01);
    wreg(3'd3, 8'h01);
    wreg(3'd5, 8'd0);
    for (int i = 0; i < 4; i++) push(8'h7E);
    rreg(3'd3, v); chk("R8 zero length", v, 8'h00);
    wreg(3'd5, 8'd3); wreg(3'd1, 8'h09);
    for (int i = 0; i < 3; i++) push(8'h7E);
    rreg(3'd3, v); chk("R8 detector off", v, 8'h00);
    // R5 software reset
    wreg(3'd1, 8'h0B); wreg(3'd1, 8'h09);
    rreg(3'd2, v); chk("R5 reset empties", v, 8'h01);
    // R9 idle timeout: 5 chars x 4 clocks = 20 clocks
    wreg(3'd7, 8'd3); wreg(3'd6, 8'd5);
    push(8'h22);
    repeat (19) @(negedge clk);
    irq_is("R9 before limit", 1'b0);
    @(negedge clk);
    irq_is("R9 at limit", 1'b1);
    wreg(3'd3, 8'h02);
    repeat (40) @(negedge clk);
    irq_is("R9 fires once", 1'b0);
    push(8'h23);
    repeat (19) @(negedge clk);
    irq_is("R9 restart before", 1'b0);
    @(negedge clk);
    irq_is("R9 restart at limit", 1'b1);
    wreg(3'd3, 8'h02);
    wreg(3'd6, 8'd0);
    repeat (40) @(negedge clk);
    irq_is("R9 zero limit", 1'b0);
    // R3 fill to depth
    wreg(3'd1, 8'h0B); wreg(3'd1, 8'h09);
    for (int i = 0; i < DEPTH; i++) push(8'(i));
    rreg(3'd2, v); chk("R3 full", v, 8'h06);
    push(8'hEE);
    rreg(3'd2, v); chk("R3 overrun", v, 8'h0E);
    rreg(3'd0, v); chk("R3 drop kept head", v, 8'h00);
    rreg(3'd2, v); chk("R3 overrun sticky", v, 8'h0C);
    rreg(3'd0, v); chk("R3 next byte", v, 8'h01);
    wreg(3'd1, 8'h0B);
    push(8'h44);
    rreg(3'd2, v); chk("R5 held empty", v, 8'h01);
    wreg(3'd1, 8'h09);
    rreg(3'd2, v); chk("R5 overrun cleared", v, 8'h01);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule